// File: doc/BRIEF.md
# Packet Receive FIFO with Overflow Recovery

This block is a byte-wide first-in first-out store that sits between a packet processor and a processor-style read port. Every byte is kept with four status bits: packet start, packet end, abort and error. The writer presents one byte per cycle with its status. The reader pulls one byte per request and gets it, with its status, on the following cycle. If the reader asks while nothing is stored, it gets an invalid-data pulse instead, and the pointers do not move.

Three fill indications are exported: empty, data available and full. Data available compares the stored byte count against a threshold set on an input. When the store is full and the writer still pushes, an overflow policy that knows about packets takes over. The offending byte is dropped and a sticky overflow flag is raised. If a packet was open at that moment, its last stored byte gets its end and abort bits set, so the reader sees a closed, aborted packet. From then on every incoming byte is thrown away until a packet-start byte arrives while at least `RESTART_ROOM` entries are free. That byte is stored and normal operation resumes.

Top module: `pkt_rx_fifo`

## Requirements
- R1: After reset the store holds nothing: `fillLevel` is 0, `isEmpty` is 1, `isFull` is 0, `overflowFlag` is 0, and `rdValid` and `rdInvalid` are 0.
- R2: Bytes leave in the order they were accepted, each with its own start, end, abort and error bits. A read request while not empty produces the byte on `rdData` and the status outputs, with `rdValid` high, in the cycle after the request.
- R3: `fillLevel` equals the number of stored bytes and never exceeds `DEPTH`. `isEmpty` is high exactly when it is 0, and `isFull` is high exactly when it equals `DEPTH`.
- R4: `isAvail` is high exactly when `fillLevel` is greater than or equal to `availLevel`.
- R5: A write while full is not stored, leaves `fillLevel` unchanged, and sets `overflowFlag` in the next cycle. This applies to a byte that carries packet start.
- R6: If a packet is open (its last accepted byte had no end bit) when a write arrives while full, the last stored byte of that packet gets its end and abort bits set. A packet that was already closed is left untouched.
- R7: After an overflow, every write is dropped until a write carrying packet start arrives while at least `RESTART_ROOM` entries (default 16) are free. That byte is stored. A start byte arriving with one entry less free is dropped.
- R8: A read request while empty leaves the contents and pointers unchanged. In the next cycle it gives `rdInvalid` high and `rdValid` low.
- R9: `overflowFlag` stays set until `ovfClear` is high in a cycle without a new overflow. After that it reads 0.
- R10: A read and a write in the same cycle while neither empty nor full both take effect, and `fillLevel` stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write strobe from the packet processor |
| wrData | input | DATA_W | Byte to store |
| wrStart | input | 1 | Byte is the first of a packet |
| wrEnd | input | 1 | Byte is the last of a packet |
| wrAbort | input | 1 | Abort status carried with the byte |
| wrErr | input | 1 | Error status carried with the byte |
| rdReq | input | 1 | Read request |
| rdData | output | DATA_W | Byte read out |
| rdStart | output | 1 | Start status of the byte read |
| rdEnd | output | 1 | End status of the byte read |
| rdAbort | output | 1 | Abort status of the byte read |
| rdErr | output | 1 | Error status of the byte read |
| rdValid | output | 1 | Read returned a stored byte |
| rdInvalid | output | 1 | Read was made while empty |
| availLevel | input | $clog2(DEPTH)+1 | Threshold for data available |
| fillLevel | output | $clog2(DEPTH)+1 | Stored byte count |
| isEmpty | output | 1 | No bytes stored |
| isAvail | output | 1 | Count at or above threshold |
| isFull | output | 1 | No free entry |
| ovfClear | input | 1 | Clears the overflow flag |
| overflowFlag | output | 1 | Sticky overflow indication |

## Verification
The hardest situation to reach is the restart boundary. The store must be completely full, must have entered the discard state, and must then be drained to exactly one entry below the restart room and to exactly the restart room, with start and non-start bytes offered at each level. The bench fills a 32-entry configuration to the brim with closed packets, overflows it, and reads precise counts before offering bytes. A second run fills the store with one open packet, so the cut-off abort mark lands on the final stored byte, and then reads that byte back.

// File: rtl/pkt_rx_fifo_pkg.sv
package pkt_rx_fifo_pkg;

  // Status carried alongside every stored byte.
  typedef struct packed {
    logic fStart;
    logic fEnd;
    logic fAbort;
    logic fErr;
  } pktStat_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic push;      // store incoming byte
    logic pop;       // return oldest byte
    logic markLast;  // close newest byte with end + abort
    logic readMiss;  // read while empty
  } fifoStrb_t;

endpackage

// File: rtl/pkt_rx_fifo_dpath.sv
module pkt_rx_fifo_dpath
  import pkt_rx_fifo_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  fifoStrb_t                 strb,
  input  logic [DATA_W-1:0]         wrData,
  input  pktStat_t                  wrStat,
  output logic [$clog2(DEPTH):0]    count,
  output logic [DATA_W-1:0]         rdData,
  output pktStat_t                  rdStat,
  output logic                      rdValid,
  output logic                      rdInvalid
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = ADDR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [DATA_W-1:0] dataMem [DEPTH];
  pktStat_t          statMem [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdPtr, lastIdx;

  assign lastIdx = wrPtr - 1'b1;

  // Storage: byte and status written together; abort mark edits newest entry.
  always_ff @(posedge clk) begin
    if (strb.push) begin
      dataMem[wrPtr] <= wrData;
      statMem[wrPtr] <= wrStat;
    end else if (strb.markLast) begin
      statMem[lastIdx].fEnd   <= 1'b1;
      statMem[lastIdx].fAbort <= 1'b1;
    end
  end

  // Pointers and fill count.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + 1'b1;
      if (strb.pop)  rdPtr <= rdPtr + 1'b1;
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // Read port registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData    <= '0;
      rdStat    <= '0;
      rdValid   <= 1'b0;
      rdInvalid <= 1'b0;
    end else begin
      rdValid   <= strb.pop;
      rdInvalid <= strb.readMiss;
      if (strb.pop) begin
        rdData <= dataMem[rdPtr];
        rdStat <= statMem[rdPtr];
      end
    end
  end

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    count <= DEPTH_C);

  p_push_grows_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.push && !strb.pop |=> count == $past(count) + 1'b1);

  p_pop_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |=> rdValid && !rdInvalid);

  p_miss_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.readMiss |=> rdInvalid && !rdValid && count == $past(count));

  p_both_level_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.push && strb.pop |=> count == $past(count));

endmodule

// File: rtl/pkt_rx_fifo_ctrl.sv
module pkt_rx_fifo_ctrl
  import pkt_rx_fifo_pkg::*;
#(
  parameter int DEPTH        = 256,
  parameter int RESTART_ROOM = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrValid,
  input  logic                    wrStart,
  input  logic                    wrEnd,
  input  logic                    rdReq,
  input  logic                    ovfClear,
  input  logic [$clog2(DEPTH):0]  count,
  output fifoStrb_t               strb,
  output logic                    overflowFlag
);

  localparam int CNT_W = $clog2(DEPTH) + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ROOM_C  = CNT_W'(RESTART_ROOM);

  logic discarding, nextDisc;
  logic inPkt, nextInPkt;
  logic setOvf;
  logic fullNow, emptyNow, restartOk;
  logic [CNT_W-1:0] freeRoom;

  assign fullNow   = (count == DEPTH_C);
  assign emptyNow  = (count == '0);
  assign freeRoom  = DEPTH_C - count;
  assign restartOk = (freeRoom >= ROOM_C);

  always_comb begin
    strb          = '0;
    nextDisc      = discarding;
    nextInPkt     = inPkt;
    setOvf        = 1'b0;
    strb.pop      = rdReq && !emptyNow;
    strb.readMiss = rdReq && emptyNow;
    if (wrValid) begin
      if (fullNow) setOvf = 1'b1;
      if (discarding) begin
        if (wrStart && restartOk) begin
          strb.push = 1'b1;
          nextDisc  = 1'b0;
          nextInPkt = !wrEnd;
        end
      end else if (fullNow) begin
        nextDisc = 1'b1;
        if (inPkt) begin
          strb.markLast = 1'b1;
          nextInPkt     = 1'b0;
        end
      end else begin
        strb.push = 1'b1;
        nextInPkt = !wrEnd;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      discarding   <= 1'b0;
      inPkt        <= 1'b0;
      overflowFlag <= 1'b0;
    end else begin
      discarding <= nextDisc;
      inPkt      <= nextInPkt;
      if (setOvf)        overflowFlag <= 1'b1;
      else if (ovfClear) overflowFlag <= 1'b0;
    end
  end

  p_full_write_ovf_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && fullNow |=> overflowFlag);

  p_full_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && fullNow && !rdReq |=> count == $past(count));

  p_discard_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    discarding && wrValid && !wrStart && !rdReq |=> count == $past(count));

  p_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    discarding && wrValid && wrStart && restartOk |=> !discarding);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    ovfClear && !(wrValid && fullNow) |=> !overflowFlag);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag && !ovfClear |=> overflowFlag);

endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo
  import pkt_rx_fifo_pkg::*;
#(
  parameter int DEPTH        = 256,
  parameter int DATA_W       = 8,
  parameter int RESTART_ROOM = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrValid,
  input  logic [DATA_W-1:0]       wrData,
  input  logic                    wrStart,
  input  logic                    wrEnd,
  input  logic                    wrAbort,
  input  logic                    wrErr,
  input  logic                    rdReq,
  output logic [DATA_W-1:0]       rdData,
  output logic                    rdStart,
  output logic                    rdEnd,
  output logic                    rdAbort,
  output logic                    rdErr,
  output logic                    rdValid,
  output logic                    rdInvalid,
  input  logic [$clog2(DEPTH):0]  availLevel,
  output logic [$clog2(DEPTH):0]  fillLevel,
  output logic                    isEmpty,
  output logic                    isAvail,
  output logic                    isFull,
  input  logic                    ovfClear,
  output logic                    overflowFlag
);

  localparam int CNT_W = $clog2(DEPTH) + 1;

  fifoStrb_t        strb;
  pktStat_t         wrStat, rdStat;
  logic [CNT_W-1:0] count;

  assign wrStat = '{fStart: wrStart, fEnd: wrEnd, fAbort: wrAbort, fErr: wrErr};

  pkt_rx_fifo_ctrl #(.DEPTH(DEPTH), .RESTART_ROOM(RESTART_ROOM)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrStart(wrStart), .wrEnd(wrEnd),
    .rdReq(rdReq), .ovfClear(ovfClear), .count(count), .strb(strb),
    .overflowFlag(overflowFlag)
  );

  pkt_rx_fifo_dpath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .wrStat(wrStat),
    .count(count), .rdData(rdData), .rdStat(rdStat), .rdValid(rdValid),
    .rdInvalid(rdInvalid)
  );

  assign rdStart   = rdStat.fStart;
  assign rdEnd     = rdStat.fEnd;
  assign rdAbort   = rdStat.fAbort;
  assign rdErr     = rdStat.fErr;
  assign fillLevel = count;
  assign isEmpty   = (count == '0);
  assign isFull    = (count == CNT_W'(DEPTH));
  assign isAvail   = (count >= availLevel);

  p_avail_r4: assert property (@(posedge clk) disable iff (!rstN)
    isAvail |-> !isEmpty || availLevel == '0);

endmodule

// File: tb/pkt_rx_fifo_tb.sv
module pkt_rx_fifo_tb;

  localparam int DEPTH = 32;
  localparam int ROOM  = 16;
  localparam int CW    = $clog2(DEPTH) + 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrValid = 0, wrStart = 0, wrEnd = 0, wrAbort = 0, wrErr = 0;
  logic [7:0] wrData = '0;
  logic rdReq = 0, ovfClear = 0;
  logic [7:0] rdData;
  logic rdStart, rdEnd, rdAbort, rdErr, rdValid, rdInvalid;
  logic [CW-1:0] availLevel = '0, fillLevel;
  logic isEmpty, isAvail, isFull, overflowFlag;

  int tests = 0, fails = 0;
  logic [11:0] expQ [$];

  always #10 clk = ~clk;

  pkt_rx_fifo #(.DEPTH(DEPTH), .DATA_W(8), .RESTART_ROOM(ROOM)) u_dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData), .wrStart(wrStart),
    .wrEnd(wrEnd), .wrAbort(wrAbort), .wrErr(wrErr), .rdReq(rdReq), .rdData(rdData),
    .rdStart(rdStart), .rdEnd(rdEnd), .rdAbort(rdAbort), .rdErr(rdErr),
    .rdValid(rdValid), .rdInvalid(rdInvalid), .availLevel(availLevel),
    .fillLevel(fillLevel), .isEmpty(isEmpty), .isAvail(isAvail), .isFull(isFull),
    .ovfClear(ovfClear), .overflowFlag(overflowFlag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setWr(input logic [7:0] d, input logic s, e, a, r);
    wrValid = 1; wrData = d; wrStart = s; wrEnd = e; wrAbort = a; wrErr = r;
  endtask

  task automatic clrWr();
    wrValid = 0; wrStart = 0; wrEnd = 0; wrAbort = 0; wrErr = 0;
  endtask

  task automatic doWrite(input logic [7:0] d, input logic s, e, a, r, input bit keep);
    setWr(d, s, e, a, r);
    cyc();
    clrWr();
    if (keep) expQ.push_back({d, s, e, a, r});
  endtask

  task automatic checkRead(input string tag);
    logic [11:0] exp;
    exp = expQ.pop_front();
    chk(rdValid == 1'b1, {tag, " rdValid"}, int'(rdValid), 1);
    chk({rdData, rdStart, rdEnd, rdAbort, rdErr} == exp, {tag, " data+status"},
        int'({rdData, rdStart, rdEnd, rdAbort, rdErr}), int'(exp));
  endtask

  task automatic doRead(input string tag);
    rdReq = 1;
    cyc();
    rdReq = 0;
    checkRead(tag);
  endtask

  task automatic checkFlags(input int lvl, input string tag);
    chk(int'(fillLevel) == lvl, {tag, " level"}, int'(fillLevel), lvl);
    chk(isEmpty == (lvl == 0), {tag, " empty"}, int'(isEmpty), int'(lvl == 0));
    chk(isFull == (lvl == DEPTH), {tag, " full"}, int'(isFull), int'(lvl == DEPTH));
    chk(isAvail == (lvl >= int'(availLevel)), {tag, " avail R4"}, int'(isAvail),
        int'(lvl >= int'(availLevel)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    chk(fillLevel == 0 && isEmpty && !isFull, "R1 level/flags", int'(fillLevel), 0);
    chk(!overflowFlag && !rdValid && !rdInvalid, "R1 status outputs",
        int'({overflowFlag, rdValid, rdInvalid}), 0);

    // R8 read while empty
    rdReq = 1; cyc(); rdReq = 0;
    chk(rdInvalid && !rdValid, "R8 invalid pulse", int'({rdInvalid, rdValid}), 2);
    chk(fillLevel == 0, "R8 level unchanged", int'(fillLevel), 0);
    cyc();
    chk(!rdInvalid, "R8 pulse ends", int'(rdInvalid), 0);

    // R2 R3 R4 sweep over packet lengths 1..DEPTH
    for (int n = 1; n <= DEPTH; n++) begin
      availLevel = CW'((n * 5) % (DEPTH + 1));
      for (int i = 0; i < n; i++) begin
        doWrite(8'((n * 7 + i * 3) & 8'hFF), i == 0, i == n - 1, 1'b0, (i % 3) == 1, 1);
        checkFlags(i + 1, "R3 fill");
      end
      for (int i = 0; i < n; i++) begin
        doRead("R2 order");
        checkFlags(n - 1 - i, "R3 drain");
      end
    end
    availLevel = CW'(4);

    // R10 simultaneous read and write
    for (int i = 0; i < 3; i++) doWrite(8'(8'h40 + i), i == 0, 1'b0, 1'b0, 1'b0, 1);
    for (int i = 0; i < 10; i++) begin
      setWr(8'(8'h50 + i), 1'b0, i == 9, 1'b0, 1'b0);
      rdReq = 1;
      cyc();
      rdReq = 0; clrWr();
      expQ.push_back({8'(8'h50 + i), 1'b0, i == 9, 1'b0, 1'b0});
      checkRead("R10 read during write");
      chk(fillLevel == 3, "R10 level steady", int'(fillLevel), 3);
    end
    while (expQ.size() > 0) doRead("R10 drain");

    // R5 R7 R9: fill with closed packets, overflow with a start byte
    for (int i = 0; i < DEPTH; i++)
      doWrite(8'(8'h80 + i), (i % 8) == 0, (i % 8) == 7, 1'b0, 1'b0, 1);
    checkFlags(DEPTH, "R5 full");
    doWrite(8'hEE, 1'b1, 1'b0, 1'b0, 1'b0, 0);
    chk(overflowFlag, "R5 overflow on start", int'(overflowFlag), 1);
    chk(fillLevel == DEPTH, "R5 start dropped", int'(fillLevel), DEPTH);
    repeat (3) cyc();
    chk(overflowFlag, "R9 sticky", int'(overflowFlag), 1);
    ovfClear = 1; cyc(); ovfClear = 0;
    chk(!overflowFlag, "R9 cleared", int'(overflowFlag), 0);
    for (int i = 0; i < ROOM - 1; i++) doRead("R7 pre-restart read");
    doWrite(8'hD1, 1'b1, 1'b1, 1'b0, 1'b0, 0);
    chk(fillLevel == DEPTH - ROOM + 1, "R7 start dropped below room",
        int'(fillLevel), DEPTH - ROOM + 1);
    doRead("R7 pre-restart read");
    doWrite(8'hD2, 1'b0, 1'b1, 1'b0, 1'b0, 0);
    chk(fillLevel == DEPTH - ROOM, "R7 non-start dropped", int'(fillLevel), DEPTH - ROOM);
    doWrite(8'hA5, 1'b1, 1'b1, 1'b0, 1'b1, 1);
    chk(fillLevel == DEPTH - ROOM + 1, "R7 start accepted at room",
        int'(fillLevel), DEPTH - ROOM + 1);
    chk(!overflowFlag, "R9 stays clear", int'(overflowFlag), 0);
    doWrite(8'hA6, 1'b1, 1'b1, 1'b0, 1'b0, 1);
    chk(fillLevel == DEPTH - ROOM + 2, "R7 normal after restart",
        int'(fillLevel), DEPTH - ROOM + 2);
    while (expQ.size() > 0) doRead("R7 R6 closed packet kept");

    // R6: one open packet fills the store, then a middle byte overflows
    for (int i = 0; i < DEPTH; i++) doWrite(8'(8'h10 + i), i == 0, 1'b0, 1'b0, 1'b0, 1);
    doWrite(8'hCC, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    expQ[expQ.size() - 1] = expQ[expQ.size() - 1] | 12'h006;
    chk(overflowFlag, "R5 overflow on middle byte", int'(overflowFlag), 1);
    chk(fillLevel == DEPTH, "R5 middle byte dropped", int'(fillLevel), DEPTH);
    while (expQ.size() > 0) doRead("R6 abort mark");
    checkFlags(0, "R6 drained");
    rdReq = 1; cyc(); rdReq = 0;
    chk(rdInvalid && !rdValid, "R8 invalid after drain", int'({rdInvalid, rdValid}), 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule